// File: doc/BRIEF.md
# Programmable Divide-by-N Down-Counter

This block divides its clock by a run-time programmable ratio N and marks every N-th clock with a one-cycle output pulse. Internally it is a mixed-radix cascade of down-counting stages: a fast first stage, three decimal stages with place values 1, 10 and 100, and a small top stage. The modulus of the first stage is 2, 4, 5, 8 or 10, chosen by a 3-bit mode input. Each time the first stage wraps, the value held in the upper stages drops by one. The jam bits the first stage does not need feed the top stage, and the place value of the top stage is 1000.

The whole cascade is preset from a 16-bit jam word. This happens automatically at each pulse, or continuously while the mode input selects the held preset state. Each decimal stage accepts presets of 10 to 15 while keeping its place value, which extends the reachable count. An optional latch input keeps the output high after a pulse. A typical use is as the programmable divider of a frequency synthesizer, or as a long time-out timer.

Top module: `divn_counter`

## Requirements
- R1: While `rst_n` is low the output is low and every stage holds zero. In a counting mode, the first clock edge after reset reaches the terminal state, so the output pulses after that edge.
- R2: The mode code `mode` = 3'b010 selects divide-by-2, 3'b011 divide-by-4, 3'b100 divide-by-5, 3'b101 divide-by-8, and 3'b110 or 3'b111 divide-by-10. The first stage takes its preset from the low w bits of `jam[3:0]`, where w is 1, 2, 3, 3 or 4 for those moduli. The remaining upper bits of `jam[3:0]` form the top-stage preset. The decimal stages take their presets from `jam[7:4]` (units), `jam[11:8]` (tens) and `jam[15:12]` (hundreds).
- R3: The ratio is N = F + M·(U + 10·T + 100·H + 1000·L), where M is the first-stage modulus, F is the first-stage preset, U, T and H are the decimal-stage presets, and L is the top-stage preset. In a counting mode the output is high for exactly one clock in every N clocks, for N of at least 3.
- R4: Decimal presets from 10 to 15 count with their nominal place value. In divide-by-8 mode with all jam bits set, N is 21327.
- R5: On the edge at which the output pulse is issued, the cascade reloads from the jam word present at that edge. A change of `jam` between pulses affects only the period that begins at the next pulse.
- R6: While `mode[2:1]` is 2'b00 (held preset), every edge loads the jam word and no new pulse is produced. After the mode returns to a counting code, the first pulse appears after exactly N clocks.
- R7: If the held preset is entered when one edge remains before a due pulse, the pulse still appears after that edge. If two edges remain, the pulse appears after the second edge.
- R8: While `latch_en` is high, the output stays high once a pulse has occurred. It falls on the first edge after `latch_en` has gone low. With `latch_en` low, each pulse lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| jam | input | 16 | Preset word for all stages |
| mode | input | 3 | First-stage modulus select, or held preset when bits [2:1] are zero |
| latch_en | input | 1 | Holds the output high after a pulse while high |
| pulse_out | output | 1 | Divided output pulse |

## Verification
A wrong value in any stage shows at the output only as a misplaced pulse. A fault in the fast first stage or in its wrap value moves the very next pulse. A fault in a decimal or top stage may stay hidden for up to the full period of N clocks. The reference therefore tracks the remaining count as one integer and compares the output on every clock. Long ratios (about 4000 and 21327) are run through complete periods so that borrows through every stage reach the output. The held-preset entry is placed exactly one and two edges before a due pulse, because those cases decide whether a pending pulse is kept.

// File: rtl/divn_counter.sv
module divn_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] jam,
  input  logic [2:0]  mode,
  input  logic        latch_en,
  output logic        pulse_out
);
  localparam logic [3:0] DEC_TOP = 4'd9;

  logic [3:0] f, d0, d1, d2;
  logic [2:0] l, div_q;
  logic       raw, prev_pre, pend;

  logic       preset, upper0, term, near2, evt;
  logic [2:0] eff, fw, l_e;
  logic [3:0] m, fmask, f_e;

  assign preset = (mode[2:1] == 2'b00);
  assign eff    = preset ? div_q : mode;

  always_comb begin
    case (eff)
      3'b010:  begin m = 4'd2; fw = 3'd1; end
      3'b011:  begin m = 4'd4; fw = 3'd2; end
      3'b100:  begin m = 4'd5; fw = 3'd3; end
      3'b101:  begin m = 4'd8; fw = 3'd3; end
      default: begin m = 4'd10; fw = 3'd4; end
    endcase
  end

  assign fmask  = 4'((5'd1 << fw) - 5'd1);
  assign f_e    = raw ? (f & fmask) : f;
  assign l_e    = raw ? 3'(f >> fw) : l;
  assign upper0 = (d0 == 4'd0) && (d1 == 4'd0) && (d2 == 4'd0) && (l_e == 3'd0);
  assign term   = upper0 && (f_e <= 4'd1);
  assign near2  = (m == 4'd2) ? ((f_e == 4'd0) && (d0 == 4'd1) && (d1 == 4'd0) &&
                                 (d2 == 4'd0) && (l_e == 3'd0))
                              : (upper0 && (f_e == 4'd2));
  assign evt    = pend | ((!preset || !prev_pre) && term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f <= '0; d0 <= '0; d1 <= '0; d2 <= '0; l <= '0;
      raw <= 1'b0; prev_pre <= 1'b1; pend <= 1'b0;
      div_q <= 3'b110; pulse_out <= 1'b0;
    end else begin
      prev_pre  <= preset;
      pend      <= preset && !prev_pre && near2;
      pulse_out <= evt | (pulse_out & latch_en);
      if (!preset) div_q <= mode;
      if (preset || term) begin
        f <= jam[3:0]; d0 <= jam[7:4]; d1 <= jam[11:8]; d2 <= jam[15:12];
        l <= 3'd0; raw <= 1'b1;
      end else begin
        raw <= 1'b0;
        if (f_e != 4'd0) begin
          f <= f_e - 4'd1; l <= l_e;
        end else begin
          f <= m - 4'd1;
          if (d0 != 4'd0) begin
            d0 <= d0 - 4'd1; l <= l_e;
          end else begin
            d0 <= DEC_TOP;
            if (d1 != 4'd0) begin
              d1 <= d1 - 4'd1; l <= l_e;
            end else begin
              d1 <= DEC_TOP;
              if (d2 != 4'd0) begin
                d2 <= d2 - 4'd1; l <= l_e;
              end else begin
                d2 <= DEC_TOP; l <= l_e - 3'd1;
              end
            end
          end
        end
      end
    end
  end

  AST_TERM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset && term) |=> pulse_out); // R3
  AST_RELOAD_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset && term) |=> (raw && f == $past(jam[3:0]))); // R5
  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (raw && {d2, d1, d0} == $past(jam[15:4]))); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (preset && $past(preset) && $past(preset, 2) && !latch_en) |=> !pulse_out); // R6
  AST_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (preset && !prev_pre && near2) |=> ##1 pulse_out); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && latch_en) |=> pulse_out); // R8
endmodule

// File: tb/test_divn_counter.sv
module test_divn_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] jam = 16'h0;
  logic [2:0]  mode = 3'b000;
  logic        latch_en = 1'b0;
  logic        pulse_out;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  bit    cmp_on = 1'b0;

  divn_counter i_divn_counter (.clk(clk), .rst_n(rst_n), .jam(jam), .mode(mode),
                               .latch_en(latch_en), .pulse_out(pulse_out));

  always #4 clk = ~clk;

  function automatic int modv(logic [2:0] c);
    case (c)
      3'b010: return 2;
      3'b011: return 4;
      3'b100: return 5;
      3'b101: return 8;
      default: return 10;
    endcase
  endfunction

  function automatic int fwv(logic [2:0] c);
    case (c)
      3'b010: return 1;
      3'b011: return 2;
      3'b100, 3'b101: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int nval(logic [15:0] j, logic [2:0] c);
    int w = fwv(c);
    int lo = int'(j[3:0]);
    return (lo % (1 << w)) + modv(c) * (int'(j[7:4]) + 10 * int'(j[11:8]) +
           100 * int'(j[15:12]) + 1000 * (lo >> w));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference: remaining count as one integer
  int         cnt, mval;
  bit         valid, prevpre, pend, expo;
  logic [15:0] snap;
  logic [2:0]  lastm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt = 0; valid = 1; prevpre = 1; pend = 0; expo = 0; lastm = 3'b110; snap = 0; mval = 0;
    end else begin
      bit pre, ev;
      int v;
      pre = (mode[2:1] == 2'b00);
      v = valid ? cnt : nval(snap, pre ? lastm : mode);
      ev = pend; pend = 0;
      if (pre) begin
        if (!prevpre) begin
          if (v <= 1) ev = 1;
          if (v == 2) pend = 1;
        end
        snap = jam; valid = 0;
      end else begin
        lastm = mode;
        if (v <= 1) begin ev = 1; snap = jam; valid = 0; end
        else begin cnt = v - 1; valid = 1; end
      end
      prevpre = pre;
      expo = ev | (expo & latch_en);
      mval = valid ? cnt : nval(snap, lastm);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && cmp_on) chk(pulse_out == expo, tag, int'(pulse_out), int'(expo));
    if (cyc > 190000) begin
      chk(1'b0, "watchdog", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_mode(logic [2:0] c, logic [15:0] j, int periods, string req);
    int n = nval(j, c);
    int hits = 0;
    tag = req;
    @(negedge clk); mode = 3'b000; jam = j;
    repeat (4) @(negedge clk);
    mode = c;
    for (int i = 1; i <= periods * n; i++) begin
      @(negedge clk);
      if (pulse_out) begin
        hits++;
        chk(i % n == 0, req, i, (i / n) * n);
      end
    end
    chk(hits == periods, req, hits, periods);
  endtask

  initial begin
    #1 chk(pulse_out == 1'b0, "R1", int'(pulse_out), 0);
    mode = 3'b110; jam = 16'h0007;
    repeat (2) @(negedge clk);
    chk(pulse_out == 1'b0, "R1", int'(pulse_out), 0);
    rst_n = 1'b1; cmp_on = 1'b1;
    @(negedge clk);
    chk(pulse_out == 1'b1, "R1", int'(pulse_out), 1);

    run_mode(3'b010, 16'h0035, 2, "R2");
    run_mode(3'b011, 16'h0126, 2, "R2");
    run_mode(3'b100, 16'h0043, 3, "R2");
    run_mode(3'b100, 16'h0027, 3, "R2");
    run_mode(3'b101, 16'h0025, 3, "R3");
    run_mode(3'b110, 16'h0137, 3, "R3");
    run_mode(3'b111, 16'h0009, 4, "R3");
    run_mode(3'b110, 16'h00F0, 2, "R4");
    chk(nval(16'hFFFF, 3'b101) == 21327, "R4", nval(16'hFFFF, 3'b101), 21327);
    run_mode(3'b101, 16'hFFFF, 2, "R4");

    // R5: jam change between pulses takes effect one period later
    begin
      int last = 0, gap_i = 0;
      int gaps [3];
      tag = "R5";
      @(negedge clk); mode = 3'b000; jam = 16'h0025;
      repeat (4) @(negedge clk);
      mode = 3'b110;
      for (int i = 1; i <= 200 && gap_i < 3; i++) begin
        @(negedge clk);
        if (pulse_out) begin
          gaps[gap_i] = i - last; last = i; gap_i++;
          if (gap_i == 1) jam = 16'h0014;
        end
      end
      chk(gaps[0] == 25, "R5", gaps[0], 25);
      chk(gaps[1] == 25, "R5", gaps[1], 25);
      chk(gaps[2] == 14, "R5", gaps[2], 14);
    end

    // R6: held preset produces no pulse
    tag = "R6";
    @(negedge clk); mode = 3'b001; jam = 16'h0003;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(pulse_out == 1'b0, "R6", int'(pulse_out), 0);
    end
    run_mode(3'b011, 16'h0031, 2, "R6");

    // R7: preset entered two, then one, edges before a due pulse
    tag = "R7";
    for (int k = 2; k >= 1; k--) begin
      for (int i = 0; i < 40 && mval != k; i++) @(negedge clk);
      chk(mval == k, "R7", mval, k);
      mode = 3'b000;
      repeat (k) @(negedge clk);
      chk(pulse_out == 1'b1, "R7", int'(pulse_out), 1);
      repeat (4) @(negedge clk);
      chk(pulse_out == 1'b0, "R7", int'(pulse_out), 0);
      mode = 3'b011;
    end

    // R8: latched output
    tag = "R8";
    @(negedge clk); mode = 3'b000; jam = 16'h0014; latch_en = 1'b1;
    repeat (4) @(negedge clk);
    mode = 3'b110;
    repeat (14) @(negedge clk);
    chk(pulse_out == 1'b1, "R8", int'(pulse_out), 1);
    repeat (20) @(negedge clk);
    chk(pulse_out == 1'b1, "R8", int'(pulse_out), 1);
    latch_en = 1'b0;
    @(negedge clk);
    chk(pulse_out == 1'b0, "R8", int'(pulse_out), 0);
    repeat (30) @(negedge clk);

    // R1: asynchronous reset in the middle of a period
    tag = "R1";
    latch_en = 1'b1;
    for (int i = 0; i < 40 && !pulse_out; i++) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk(pulse_out == 1'b0, "R1", int'(pulse_out), 0);
    @(negedge clk); latch_en = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    chk(pulse_out == 1'b1, "R1", int'(pulse_out), 1);
    repeat (30) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule